// File: doc/BRIEF.md
# Barrel Shifter with Flag Rules

This is a purely combinational shifter for the execute stage of a processor that uses a compact 16-bit instruction encoding. It performs four operations on a WIDTH-bit operand (32 by default): logical left, logical right, arithmetic right and rotate right. Alongside the shifted value it returns the new negative, zero and carry flags. The overflow flag is not touched here and stays with the caller.

The shift count comes from one of two places. One is a short immediate field of $clog2(WIDTH) bits. The other is the least significant byte of a register value. The two sources treat a count of zero differently. A register count of zero is an identity. An immediate count of zero on a right shift stands for a full-width shift. Counts equal to WIDTH and counts above WIDTH each have their own carry rule. The block is placed between operand read and writeback and needs no clock.

Top module: `shf_unit`

## Requirements
- R1: A register-sourced count (`amt_from_reg` = 1) uses only bits 7:0 of `amt_reg`. The bits above them never change the result or the flags.
- R2: A register count byte of 0, or an immediate count of 0 on a left shift, gives `res` = `op_a` and `c_out` = `c_in`.
- R3: `shift_kind` encoding is 00 left, 01 logical right, 10 arithmetic right, 11 rotate right. For a count k from 1 to 31, left gives `op_a << k` with carry `op_a[32-k]`. Logical right gives `op_a >> k` and arithmetic right gives the sign-filled shift; both set the carry to `op_a[k-1]`.
- R4: An immediate logical right shift with count 0 behaves as a shift by 32. The result is 0 and the carry is `op_a[31]`.
- R5: An immediate arithmetic right shift with count 0 behaves as a shift by 32. Every result bit equals `op_a[31]` and the carry is `op_a[31]`.
- R6: A register left shift by exactly 32 gives 0 with carry `op_a[0]`. A register left shift by 33 to 255 gives 0 with the carry cleared.
- R7: A register logical right shift by exactly 32 gives 0 with carry `op_a[31]`. A register logical right shift by 33 to 255 gives 0 with the carry cleared.
- R8: A register arithmetic right shift by 32 or more gives every bit equal to `op_a[31]`, and the carry equals `op_a[31]`.
- R9: A register rotate uses count bits 4:0. If those bits are nonzero (r), the result is `op_a` rotated right by r and the carry is `op_a[r-1]`. If those bits are zero but the byte is nonzero, the result is `op_a` unchanged and the carry is `op_a[31]`.
- R10: A rotate with an immediate count passes `op_a` through with `c_out` = `c_in`, whatever the count.
- R11: `n_out` always equals bit 31 of `res` and `z_out` is 1 exactly when `res` is 0. This holds in every case, including the identity cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand to shift |
| amt_from_reg | input | 1 | 1: count from `amt_reg` low byte, 0: count from `imm_amt` |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| imm_amt | input | $clog2(WIDTH) | Immediate count field |
| amt_reg | input | WIDTH | Register value holding the count in its low byte |
| c_in | input | 1 | Current carry flag |
| res | output | WIDTH | Shifted result |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |

## Verification
The barrel path and the special-count override both respond to the same inputs, so for one count they can disagree about the result. This happens at the boundaries: 0, 31, 32, 33 and 255, from either source. The bench sweeps those counts for every shift kind, with operands whose top and bottom bits differ, and with both carry-in values. For each input set the queued expectation comes from an independent model of the rules, so a result or carry produced by the wrong path is reported against the rule that applies.

// File: rtl/shf_pkg.sv
package shf_pkg;

   // Shift operation encoding, as decoded from the instruction.
   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;

   // How the effective count relates to the data width.
   typedef enum logic [1:0] {
      AC_KEEP   = 2'b00,   // identity, carry untouched
      AC_PART   = 2'b01,   // 1 .. WIDTH-1 through the barrel
      AC_FULL   = 2'b10,   // exactly WIDTH
      AC_BEYOND = 2'b11    // above WIDTH
   } amt_class_e;

endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode
   import shf_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int REG_BYTE_W = 8,
   parameter int LW         = $clog2(WIDTH)
) (
   input  logic                  from_reg,
   input  shift_kind_e           kind,
   input  logic [LW-1:0]         imm_amt,
   input  logic [REG_BYTE_W-1:0] reg_byte,
   output amt_class_e            cls,
   output logic [LW-1:0]         cnt
);

   localparam logic [REG_BYTE_W-1:0] FULL_BYTE = REG_BYTE_W'(WIDTH);

   logic byte_zero;
   logic low_zero;

   always_comb begin
      byte_zero = (reg_byte == '0);
      low_zero  = (reg_byte[LW-1:0] == '0);
      cls       = AC_KEEP;
      cnt       = '0;
      if (from_reg) begin
         if (byte_zero) begin
            cls = AC_KEEP;
         end else if (kind == SK_ROR) begin
            cnt = reg_byte[LW-1:0];
            cls = low_zero ? AC_FULL : AC_PART;
         end else if (reg_byte < FULL_BYTE) begin
            cnt = reg_byte[LW-1:0];
            cls = AC_PART;
         end else if (reg_byte == FULL_BYTE) begin
            cls = AC_FULL;
         end else begin
            cls = AC_BEYOND;
         end
      end else begin
         if (kind == SK_ROR) begin
            cls = AC_KEEP;
         end else if (imm_amt == '0) begin
            cls = (kind == SK_LSL) ? AC_KEEP : AC_FULL;
         end else begin
            cnt = imm_amt;
            cls = AC_PART;
         end
      end
   end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
   import shf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int LW    = $clog2(WIDTH)
) (
   input  shift_kind_e       kind,
   input  logic [WIDTH-1:0]  op,
   input  logic [LW-1:0]     cnt,
   output logic [WIDTH-1:0]  shifted,
   output logic              last_out
);

   logic [WIDTH-1:0]       op_rev;
   logic [WIDTH-1:0]       src;
   logic [WIDTH-1:0]       out_rev;
   logic                   fill;
   logic [LW:0][WIDTH-1:0] stage;

   // Left shifts run through the right-shift network on a mirrored operand.
   for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
      assign op_rev[i]  = op[WIDTH-1-i];
      assign out_rev[i] = stage[LW][WIDTH-1-i];
   end

   assign src      = (kind == SK_LSL) ? op_rev : op;
   assign fill     = (kind == SK_ASR) & op[WIDTH-1];
   assign stage[0] = src;

   for (genvar s = 0; s < LW; s++) begin : g_stage
      localparam int SH = 1 << s;
      logic [WIDTH-1:0] moved;
      assign moved = (kind == SK_ROR) ? {stage[s][SH-1:0], stage[s][WIDTH-1:SH]}
                                      : {{SH{fill}}, stage[s][WIDTH-1:SH]};
      assign stage[s+1] = cnt[s] ? moved : stage[s];
   end

   assign shifted  = (kind == SK_LSL) ? out_rev : stage[LW];
   // Last bit to leave the word: bit cnt-1 of the (mirrored) source.
   assign last_out = src[cnt - 1'b1];

endmodule

// File: rtl/shf_result_sel.sv
module shf_result_sel
   import shf_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  amt_class_e        cls,
   input  shift_kind_e       kind,
   input  logic [WIDTH-1:0]  op,
   input  logic              c_in,
   input  logic [WIDTH-1:0]  shifted,
   input  logic              last_out,
   output logic [WIDTH-1:0]  res,
   output logic              c_out,
   output logic              n_out,
   output logic              z_out
);

   logic sign;
   assign sign = op[WIDTH-1];

   always_comb begin
      res   = op;
      c_out = c_in;
      unique case (cls)
         AC_KEEP: begin
            res   = op;
            c_out = c_in;
         end
         AC_PART: begin
            res   = shifted;
            c_out = last_out;
         end
         AC_FULL: begin
            unique case (kind)
               SK_LSL: begin res = '0;            c_out = op[0]; end
               SK_LSR: begin res = '0;            c_out = sign;  end
               SK_ASR: begin res = {WIDTH{sign}}; c_out = sign;  end
               SK_ROR: begin res = op;            c_out = sign;  end
            endcase
         end
         AC_BEYOND: begin
            if (kind == SK_ASR) begin
               res   = {WIDTH{sign}};
               c_out = sign;
            end else begin
               res   = '0;
               c_out = 1'b0;
            end
         end
      endcase
      n_out = res[WIDTH-1];
      z_out = (res == '0);
   end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter  int WIDTH      = 32,
   parameter  int REG_BYTE_W = 8,
   localparam int LW         = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic             amt_from_reg,
   input  logic [1:0]       shift_kind,
   input  logic [LW-1:0]    imm_amt,
   input  logic [WIDTH-1:0] amt_reg,
   input  logic             c_in,
   output logic [WIDTH-1:0] res,
   output logic             n_out,
   output logic             z_out,
   output logic             c_out
);

   if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("shf_unit: WIDTH must be a power of two of at least 8");
   end
   if (REG_BYTE_W <= LW || REG_BYTE_W > WIDTH) begin : g_bad_byte
      $error("shf_unit: REG_BYTE_W must exceed log2(WIDTH) and fit in WIDTH");
   end

   shift_kind_e           kind_e;
   amt_class_e            cls;
   logic [LW-1:0]         cnt;
   logic [WIDTH-1:0]      shifted;
   logic                  last_out;
   logic [REG_BYTE_W-1:0] reg_byte;

   assign kind_e   = shift_kind_e'(shift_kind);
   assign reg_byte = amt_reg[REG_BYTE_W-1:0];

   if (REG_BYTE_W < WIDTH) begin : g_hi_drop
      logic unused_hi;
      assign unused_hi = ^amt_reg[WIDTH-1:REG_BYTE_W];
   end

   shf_amt_decode #(.WIDTH(WIDTH), .REG_BYTE_W(REG_BYTE_W), .LW(LW)) u_dec (
      .from_reg (amt_from_reg),
      .kind     (kind_e),
      .imm_amt  (imm_amt),
      .reg_byte (reg_byte),
      .cls      (cls),
      .cnt      (cnt)
   );

   shf_barrel #(.WIDTH(WIDTH), .LW(LW)) u_bar (
      .kind     (kind_e),
      .op       (op_a),
      .cnt      (cnt),
      .shifted  (shifted),
      .last_out (last_out)
   );

   shf_result_sel #(.WIDTH(WIDTH)) u_sel (
      .cls      (cls),
      .kind     (kind_e),
      .op       (op_a),
      .c_in     (c_in),
      .shifted  (shifted),
      .last_out (last_out),
      .res      (res),
      .c_out    (c_out),
      .n_out    (n_out),
      .z_out    (z_out)
   );

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
   parameter  int WIDTH      = 32,
   parameter  int REG_BYTE_W = 8,
   localparam int LW         = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] op_a,
   input logic             amt_from_reg,
   input logic [1:0]       shift_kind,
   input logic [LW-1:0]    imm_amt,
   input logic [WIDTH-1:0] amt_reg,
   input logic             c_in,
   input logic [WIDTH-1:0] res,
   input logic             n_out,
   input logic             z_out,
   input logic             c_out
);

   localparam logic [REG_BYTE_W-1:0] FULL_BYTE = REG_BYTE_W'(WIDTH);

   logic [REG_BYTE_W-1:0] cb;
   logic                  known;

   assign cb    = amt_reg[REG_BYTE_W-1:0];
   assign known = !$isunknown({op_a, amt_from_reg, shift_kind, imm_amt, amt_reg, c_in,
                               res, n_out, z_out, c_out});

   always_comb begin
      if (known) begin
         if (amt_from_reg && cb == '0) begin
            a_r2_zero_byte_keeps: assert (res == op_a && c_out == c_in);
            a_r11_flags_on_identity: assert (z_out == (op_a == '0) && n_out == op_a[WIDTH-1]);
         end
         if (!amt_from_reg && shift_kind == 2'b11) begin
            a_r10_imm_rotate_passes: assert (res == op_a && c_out == c_in);
         end
         if (!amt_from_reg && shift_kind == 2'b01 && imm_amt == '0) begin
            a_r4_imm_lsr_full: assert (res == '0 && c_out == op_a[WIDTH-1]);
         end
         if (amt_from_reg && shift_kind == 2'b00 && cb > FULL_BYTE) begin
            a_r6_lsl_beyond_clears: assert (res == '0 && !c_out);
         end
         if (amt_from_reg && shift_kind == 2'b01 && cb > FULL_BYTE) begin
            a_r7_lsr_beyond_clears: assert (res == '0 && !c_out);
         end
         if (amt_from_reg && shift_kind == 2'b10 && cb >= FULL_BYTE) begin
            a_r8_asr_sign_fill: assert (res == {WIDTH{op_a[WIDTH-1]}} && c_out == op_a[WIDTH-1]);
         end
      end
   end

endmodule

bind shf_unit shf_unit_chk #(.WIDTH(WIDTH), .REG_BYTE_W(REG_BYTE_W)) u_shf_chk (
   .op_a         (op_a),
   .amt_from_reg (amt_from_reg),
   .shift_kind   (shift_kind),
   .imm_amt      (imm_amt),
   .amt_reg      (amt_reg),
   .c_in         (c_in),
   .res          (res),
   .n_out        (n_out),
   .z_out        (z_out),
   .c_out        (c_out)
);

// File: tb/tb_shf_unit.sv
`timescale 1ns/1ps
module tb_shf_unit;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] op_a;
   logic         amt_from_reg;
   logic [1:0]   shift_kind;
   logic [4:0]   imm_amt;
   logic [W-1:0] amt_reg;
   logic         c_in;
   logic [W-1:0] res;
   logic         n_out, z_out, c_out;

   always #2.5 clk = ~clk;

   shf_unit dut (
      .op_a (op_a), .amt_from_reg (amt_from_reg), .shift_kind (shift_kind),
      .imm_amt (imm_amt), .amt_reg (amt_reg), .c_in (c_in),
      .res (res), .n_out (n_out), .z_out (z_out), .c_out (c_out)
   );

   typedef struct {
      string        tag;
      logic [W-1:0] a;
      logic [1:0]   kind;
      logic         fr;
      int           amt;
      logic [W-1:0] res;
      logic         c;
      logic         n;
      logic         z;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;

   // Independent rule model: returns {carry, result}.
   function automatic logic [W:0] model(logic [1:0] kind, logic fr, logic [W-1:0] a,
                                        int amt, logic cin);
      int r;
      if (fr && amt == 0) return {cin, a};
      if (!fr) begin
         if (kind == 2'b11) return {cin, a};
         if (amt == 0) begin
            if (kind == 2'b00) return {cin, a};
            amt = 32;
         end
      end
      case (kind)
         2'b00: begin
            if (amt < 32)       return {a[32-amt], a << amt};
            else if (amt == 32) return {a[0], 32'h0};
            else                return {1'b0, 32'h0};
         end
         2'b01: begin
            if (amt < 32)       return {a[amt-1], a >> amt};
            else if (amt == 32) return {a[31], 32'h0};
            else                return {1'b0, 32'h0};
         end
         2'b10: begin
            if (amt < 32) return {a[amt-1], W'($signed(a) >>> amt)};
            else          return {a[31], {W{a[31]}}};
         end
         default: begin
            r = amt % 32;
            if (r == 0) return {a[31], a};
            return {a[r-1], (a >> r) | (a << (32 - r))};
         end
      endcase
   endfunction

   function automatic string tag_for(logic [1:0] kind, logic fr, int amt);
      if (!fr) begin
         if (kind == 2'b11) return "R10";
         if (amt == 0) begin
            if (kind == 2'b00) return "R2";
            if (kind == 2'b01) return "R4";
            return "R5";
         end
         return "R3";
      end
      if (amt == 0)      return "R2";
      if (kind == 2'b11) return "R9";
      if (amt < 32)      return "R3";
      if (kind == 2'b00) return "R6";
      if (kind == 2'b01) return "R7";
      return "R8";
   endfunction

   // Driver: applies inputs at the falling edge and queues the expectation.
   task automatic drive(string tag, logic [W-1:0] a, logic [1:0] kind, logic fr,
                        logic [4:0] imm, logic [W-1:0] regv, logic cin);
      item_t      it;
      logic [W:0] m;
      int         amt;
      @(negedge clk);
      op_a = a; shift_kind = kind; amt_from_reg = fr;
      imm_amt = imm; amt_reg = regv; c_in = cin;
      amt    = fr ? int'(regv[7:0]) : int'(imm);
      m      = model(kind, fr, a, amt, cin);
      it.tag = tag; it.a = a; it.kind = kind; it.fr = fr; it.amt = amt;
      it.res = m[W-1:0]; it.c = m[W];
      it.n   = m[W-1]; it.z = (m[W-1:0] == '0);
      q.push_back(it);
   endtask

   // Monitor: compares at the rising edge, half a period after the inputs moved.
   always @(posedge clk) begin
      item_t e;
      if (!rst && q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (res !== e.res || c_out !== e.c) begin
            errors++;
            $display("FAIL %s kind=%b reg=%0d amt=%0d a=%h: res=%h c=%b expected res=%h c=%b",
                     e.tag, e.kind, e.fr, e.amt, e.a, res, c_out, e.res, e.c);
         end
         checks++;
         if (n_out !== e.n || z_out !== e.z) begin
            errors++;
            $display("FAIL R11 (%s) kind=%b amt=%0d: n=%b z=%b expected n=%b z=%b",
                     e.tag, e.kind, e.amt, n_out, z_out, e.n, e.z);
         end
      end
   end

   initial begin
      int amts[6] = '{0, 1, 31, 32, 33, 255};
      logic [W-1:0] ops[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C, 32'h0000_0000};
      rst = 1'b1;
      op_a = '0; amt_from_reg = 1'b0; shift_kind = 2'b00;
      imm_amt = '0; amt_reg = '0; c_in = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Boundary sweep over all kinds, both sources, several operands and carry-ins.
      for (int o = 0; o < 4; o++) begin
         for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 6; i++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  drive(tag_for(2'(k), 1'b1, amts[i]), ops[o], 2'(k), 1'b1,
                        5'd0, W'(amts[i]), 1'(ci));
                  if (amts[i] < 32)
                     drive(tag_for(2'(k), 1'b0, amts[i]), ops[o], 2'(k), 1'b0,
                           5'(amts[i]), 32'h0, 1'(ci));
               end
            end
         end
      end

      // Mid-range counts through the barrel (R3, R9).
      for (int k = 0; k < 4; k++) begin
         for (int s = 2; s < 31; s += 7) begin
            drive(tag_for(2'(k), 1'b1, s), 32'hC0DE_F00D, 2'(k), 1'b1, 5'd0, W'(s), 1'b0);
            drive(tag_for(2'(k), 1'b0, s), 32'h9234_5678, 2'(k), 1'b0, 5'(s), 32'h0, 1'b1);
         end
      end

      // R9: byte nonzero with low five bits zero (64, 96, 224).
      drive("R9", 32'h8000_0003, 2'b11, 1'b1, 5'd0, 32'd64, 1'b0);
      drive("R9", 32'h4000_0002, 2'b11, 1'b1, 5'd0, 32'd96, 1'b1);
      drive("R9", 32'h0000_0000, 2'b11, 1'b1, 5'd0, 32'd224, 1'b1);

      // R1: upper register bits set must not matter.
      drive("R1", 32'h8765_4321, 2'b00, 1'b1, 5'd0, 32'hFFFF_FF00, 1'b1);
      drive("R1", 32'h8765_4321, 2'b01, 1'b1, 5'd0, 32'h1234_0004, 1'b0);
      drive("R1", 32'h8765_4321, 2'b10, 1'b1, 5'd0, 32'hFFFF_0120, 1'b0);
      drive("R1", 32'h8765_4321, 2'b11, 1'b1, 5'd0, 32'hABCD_EF08, 1'b1);
      drive("R1", 32'h8765_4321, 2'b00, 1'b1, 5'd0, 32'h0100_0021, 1'b1);

      // R10: immediate rotate with various counts is a pass-through.
      drive("R10", 32'hDEAD_BEEF, 2'b11, 1'b0, 5'd17, 32'h0, 1'b1);
      drive("R10", 32'h0000_0000, 2'b11, 1'b0, 5'd3, 32'h0, 1'b0);

      wait (q.size() == 0);
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not end, actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule